// File: doc/BRIEF.md
# Fetch Fault Reset Detector

This block sits beside a small 8-bit processor and watches its read bus and its instruction decoder. Every cycle it decides whether the processor has done something that must force a system reset: fetched an opcode from an address that holds neither flash nor RAM, executed an instruction the decoder marks as illegal or the low-power halt instruction, or found the reset vector erased while fetching it. Each such event becomes a one-cycle reset request, with a cause vector that a separate reset sequencer reads to record why the reset happened.

The flash and RAM windows are parameters, each given as an inclusive start and end address. Data reads are never checked against the map. Only opcode fetches are. The halt instruction counts as illegal because the device runs with stop mode disabled. The vector check reads the two reset vector bytes in order, high byte first. When both read as all ones, the block raises a monitor-entry request and sets a sticky flag that tells the boot logic to enter monitor mode on the next reset exit. Only power-on reset clears that flag.

Top module: `ffr_top`

## Requirements
- R1: An opcode fetch (`bus_vld`=1, `bus_is_op`=1) from an address outside both windows produces, on the next clock, `rst_req`=1 with `rst_cause[1]` (illegal address) set.
- R2: A data read (`bus_vld`=1, `bus_is_op`=0) never raises an illegal-address cause, whatever its address.
- R3: An opcode fetch from any address in a window, the inclusive start and end addresses included, raises no illegal-address cause.
- R4: A decoded instruction (`dec_vld`=1) flagged by `dec_illegal` produces, on the next clock, `rst_req`=1 with `rst_cause[0]` (illegal opcode) set.
- R5: A decoded halt instruction (`dec_vld`=1, `dec_halt`=1) produces the illegal-opcode cause `rst_cause[0]` on the next clock.
- R6: `dec_illegal` and `dec_halt` have no effect while `dec_vld`=0.
- R7: A vector byte read (`bus_vld`=1, `vec_rd`=1) with `vec_lo`=0 is the high byte and one with `vec_lo`=1 is the low byte. A low-byte read of 0xFF that follows a high-byte read of 0xFF produces, on the next clock, `rst_req`=1 with `rst_cause[2]` (monitor entry) set. If either byte is not 0xFF, no monitor cause is raised.
- R8: `force_mon` rises together with the monitor-entry cause, stays set through `rst`, and is cleared only by `por_rst`.
- R9: Causes that arise in the same cycle are all reported together in a single request.
- R10: `rst_req` is high exactly in the cycles where `rst_cause` is nonzero. Each faulting input cycle yields one request cycle, and with no fault the request falls again. After `rst` or `por_rst`, `rst_req` and `rst_cause` are zero.
- R11: With `bus_vld`=0, no address or vector cause is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high; keeps `force_mon` |
| por_rst | input | 1 | Synchronous power-on reset, active high; clears everything |
| bus_vld | input | 1 | A bus read happens this cycle |
| bus_is_op | input | 1 | The read is an opcode fetch (0: data read) |
| bus_addr | input | 16 | Read address |
| bus_data | input | 8 | Byte returned by the read |
| vec_rd | input | 1 | The read is a reset vector byte fetch |
| vec_lo | input | 1 | Vector byte select: 0 high byte, 1 low byte |
| dec_vld | input | 1 | Decoder output valid this cycle |
| dec_illegal | input | 1 | Decoder marks the opcode illegal |
| dec_halt | input | 1 | Decoder saw the halt instruction |
| rst_req | output | 1 | One-cycle reset request |
| rst_cause | output | 3 | Cause: bit0 illegal opcode, bit1 illegal address, bit2 monitor entry |
| force_mon | output | 1 | Sticky request to enter monitor mode on reset exit |

## Verification
Opcode fetches are driven at each window's first and last address and at the address just outside each one, then repeated as data reads and with `bus_vld` low. These runs separate the inclusive bound compares and the opcode qualifier. Decoder flags are applied with `dec_vld` both high and low. The vector pairs (erased/erased, erased/programmed, programmed/erased) show whether both bytes are required. A combined cycle, sticky-flag runs across `rst` and `por_rst`, and a long random stream are compared cycle by cycle against a behavioural model in the bench.

// File: rtl/ffr_pkg.sv
package ffr_pkg;

    // Cause vector carried to the reset sequencer: bit2 mon, bit1 addr, bit0 op
    typedef struct packed {
        logic mon;
        logic addr;
        logic op;
    } ffr_cause_t;

    localparam int CAUSE_W = $bits(ffr_cause_t);
    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    localparam ffr_cause_t CAUSE_NONE = '{mon: 1'b0, addr: 1'b0, op: 1'b0};

    function automatic logic cause_any(input ffr_cause_t c);
        return c.mon | c.addr | c.op;
    endfunction

    function automatic ffr_cause_t cause_merge(input logic op_f,
                                               input logic addr_f,
                                               input logic mon_f);
        ffr_cause_t c;
        c.op   = op_f;
        c.addr = addr_f;
        c.mon  = mon_f;
        return c;
    endfunction

endpackage

// File: rtl/ffr_addr_chk.sv
module ffr_addr_chk #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] FLASH_LO = 16'hC000,
    parameter logic [ADDR_W-1:0] FLASH_HI = 16'hFFFF,
    parameter logic [ADDR_W-1:0] RAM_LO   = 16'h0060,
    parameter logic [ADDR_W-1:0] RAM_HI   = 16'h035F
) (
    input  logic              bus_vld,
    input  logic              bus_is_op,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              fault
);
    logic in_flash;
    logic in_ram;
    logic mapped;

    always_comb begin
        in_flash = (bus_addr >= FLASH_LO) && (bus_addr <= FLASH_HI);
        in_ram   = (bus_addr >= RAM_LO)   && (bus_addr <= RAM_HI);
        mapped   = in_flash | in_ram;
        // only an opcode fetch is held against the map
        fault    = bus_vld & bus_is_op & ~mapped;
    end

    always_comb begin
        if (bus_vld && !bus_is_op)
            AST_DATA_READ_SILENT: assert (!fault); // R2
    end

endmodule

// File: rtl/ffr_op_chk.sv
module ffr_op_chk #(
    parameter bit HALT_ILLEGAL = 1'b1
) (
    input  logic dec_vld,
    input  logic dec_illegal,
    input  logic dec_halt,
    output logic fault
);
    logic halt_bad;

    generate
        if (HALT_ILLEGAL) begin : g_halt_off
            // stop mode disabled: the halt instruction is an illegal opcode
            assign halt_bad = dec_halt;
        end else begin : g_halt_on
            assign halt_bad = 1'b0;
        end
    endgenerate

    assign fault = dec_vld & (dec_illegal | halt_bad);

    always_comb begin
        if (!dec_vld)
            AST_DECODE_GATED: assert (!fault); // R6
    end

endmodule

// File: rtl/ffr_vec_chk.sv
module ffr_vec_chk
    import ffr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              srst,
    input  logic              vec_stb,
    input  logic              vec_lo,
    input  logic [DATA_W-1:0] bus_data,
    output logic              fault
);
    localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

    logic hi_erased_q;
    logic byte_erased;

    assign byte_erased = (bus_data == ERASED);

    // remember whether the high vector byte read erased
    always_ff @(posedge clk) begin
        if (srst)
            hi_erased_q <= 1'b0;
        else if (vec_stb && !vec_lo)
            hi_erased_q <= byte_erased;
    end

    assign fault = vec_stb & vec_lo & byte_erased & hi_erased_q;

    AST_VEC_NEED_LOW_ERASED: assert property (@(posedge clk) disable iff (srst)
        (vec_stb && vec_lo && !byte_erased) |-> !fault); // R7

    AST_VEC_NEED_HIGH_ERASED: assert property (@(posedge clk) disable iff (srst)
        (vec_stb && !vec_lo && !byte_erased) |=> !(vec_lo && fault)); // R7

endmodule

// File: rtl/ffr_top.sv
module ffr_top
    import ffr_pkg::*;
#(
    parameter int                ADDR_W       = 16,
    parameter int                DATA_W       = 8,
    parameter logic [ADDR_W-1:0] FLASH_LO     = 16'hC000,
    parameter logic [ADDR_W-1:0] FLASH_HI     = 16'hFFFF,
    parameter logic [ADDR_W-1:0] RAM_LO       = 16'h0060,
    parameter logic [ADDR_W-1:0] RAM_HI       = 16'h035F,
    parameter bit                HALT_ILLEGAL = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               por_rst,
    input  logic               bus_vld,
    input  logic               bus_is_op,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_data,
    input  logic               vec_rd,
    input  logic               vec_lo,
    input  logic               dec_vld,
    input  logic               dec_illegal,
    input  logic               dec_halt,
    output logic               rst_req,
    output logic [CAUSE_W-1:0] rst_cause,
    output logic               force_mon
);
    logic       any_rst;
    logic       vec_stb;
    logic       addr_fault;
    logic       op_fault;
    logic       mon_fault;
    ffr_cause_t cause_d;
    ffr_cause_t cause_q;
    logic       force_q;

    assign any_rst = rst | por_rst;
    assign vec_stb = bus_vld & vec_rd;

    ffr_addr_chk #(
        .ADDR_W   (ADDR_W),
        .FLASH_LO (FLASH_LO),
        .FLASH_HI (FLASH_HI),
        .RAM_LO   (RAM_LO),
        .RAM_HI   (RAM_HI)
    ) u_addr (
        .bus_vld   (bus_vld),
        .bus_is_op (bus_is_op),
        .bus_addr  (bus_addr),
        .fault     (addr_fault)
    );

    ffr_op_chk #(
        .HALT_ILLEGAL (HALT_ILLEGAL)
    ) u_op (
        .dec_vld     (dec_vld),
        .dec_illegal (dec_illegal),
        .dec_halt    (dec_halt),
        .fault       (op_fault)
    );

    ffr_vec_chk #(
        .DATA_W (DATA_W)
    ) u_vec (
        .clk      (clk),
        .srst     (any_rst),
        .vec_stb  (vec_stb),
        .vec_lo   (vec_lo),
        .bus_data (bus_data),
        .fault    (mon_fault)
    );

    assign cause_d = cause_merge(op_fault, addr_fault, mon_fault);

    always_ff @(posedge clk) begin
        if (any_rst)
            cause_q <= CAUSE_NONE;
        else
            cause_q <= cause_d;
    end

    // sticky monitor request: survives system reset, cleared by power-on only
    always_ff @(posedge clk) begin
        if (por_rst)
            force_q <= 1'b0;
        else if (!rst && mon_fault)
            force_q <= 1'b1;
    end

    assign rst_req   = cause_any(cause_q);
    assign rst_cause = cause_q;
    assign force_mon = force_q;

    AST_ADDR_FAULT: assert property (@(posedge clk) disable iff (any_rst)
        (bus_vld && bus_is_op &&
         !((bus_addr >= FLASH_LO) && (bus_addr <= FLASH_HI)) &&
         !((bus_addr >= RAM_LO) && (bus_addr <= RAM_HI)))
        |=> (rst_req && rst_cause[1])); // R1

    AST_DATA_NO_ADDR: assert property (@(posedge clk) disable iff (any_rst)
        (bus_vld && !bus_is_op) |=> !rst_cause[1]); // R2

    AST_ILLEGAL_OP: assert property (@(posedge clk) disable iff (any_rst)
        (dec_vld && dec_illegal) |=> (rst_req && rst_cause[0])); // R4

    AST_HALT_OP: assert property (@(posedge clk) disable iff (any_rst)
        (dec_vld && dec_halt && HALT_ILLEGAL) |=> rst_cause[0]); // R5

    AST_NO_DECODE: assert property (@(posedge clk) disable iff (any_rst)
        !dec_vld |=> !rst_cause[0]); // R6

    AST_MON_SETS_FLAG: assert property (@(posedge clk) disable iff (any_rst)
        rst_cause[2] |-> force_mon); // R8

    AST_FORCE_STICKY: assert property (@(posedge clk) disable iff (por_rst)
        force_mon |=> force_mon); // R8

    AST_IDLE_BUS: assert property (@(posedge clk) disable iff (any_rst)
        !bus_vld |=> !(rst_cause[1] || rst_cause[2])); // R11

    AST_REQ_FALLS: assert property (@(posedge clk) disable iff (any_rst)
        (!bus_vld && !dec_vld) |=> !rst_req); // R10

endmodule

// File: tb/tb_ffr_top.sv
module tb_ffr_top;
    localparam logic [15:0] F_LO = 16'hC000;
    localparam logic [15:0] F_HI = 16'hFFFF;
    localparam logic [15:0] R_LO = 16'h0060;
    localparam logic [15:0] R_HI = 16'h035F;

    logic        clk = 1'b0;
    logic        rst, por_rst, bus_vld, bus_is_op, vec_rd, vec_lo;
    logic        dec_vld, dec_illegal, dec_halt;
    logic [15:0] bus_addr;
    logic [7:0]  bus_data;
    logic        rst_req, force_mon;
    logic [2:0]  rst_cause;

    int    checks = 0;
    int    fails  = 0;
    int    cycles = 0;
    bit    done   = 1'b0;
    string cur_req = "R10";

    // behavioural reference state
    logic [2:0] m_cause = 3'b000;
    logic       m_force = 1'b0;
    logic       m_hi_ff = 1'b0;

    always #10 clk = ~clk;

    ffr_top dut (
        .clk(clk), .rst(rst), .por_rst(por_rst), .bus_vld(bus_vld),
        .bus_is_op(bus_is_op), .bus_addr(bus_addr), .bus_data(bus_data),
        .vec_rd(vec_rd), .vec_lo(vec_lo), .dec_vld(dec_vld),
        .dec_illegal(dec_illegal), .dec_halt(dec_halt),
        .rst_req(rst_req), .rst_cause(rst_cause), .force_mon(force_mon)
    );

    function automatic bit mapped(input logic [15:0] a);
        int ai = int'(a);
        if (ai >= int'(F_LO) && ai <= int'(F_HI)) return 1'b1;
        if (ai >= int'(R_LO) && ai <= int'(R_HI)) return 1'b1;
        return 1'b0;
    endfunction

    // reference model, evaluated on the inputs seen at each rising edge
    always @(posedge clk) begin
        logic [2:0] nc;
        nc = 3'b000;
        if (por_rst || rst) begin
            m_cause <= 3'b000;
            m_hi_ff <= 1'b0;
            if (por_rst) m_force <= 1'b0;
        end else begin
            if (dec_vld && (dec_illegal || dec_halt)) nc[0] = 1'b1;
            if (bus_vld && bus_is_op && !mapped(bus_addr)) nc[1] = 1'b1;
            if (bus_vld && vec_rd) begin
                if (!vec_lo) m_hi_ff <= (bus_data == 8'hFF);
                else if (m_hi_ff && bus_data == 8'hFF) nc[2] = 1'b1;
            end
            m_cause <= nc;
            if (nc[2]) m_force <= 1'b1;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rst_cause !== m_cause || rst_req !== (m_cause != 3'b000) ||
                force_mon !== m_force) begin
                fails++;
                $display("FAIL %s model: cause=%b req=%b force=%b expected cause=%b req=%b force=%b",
                         cur_req, rst_cause, rst_req, force_mon,
                         m_cause, (m_cause != 3'b000), m_force);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    task automatic idle_in();
        bus_vld = 0; bus_is_op = 0; bus_addr = 16'h0000; bus_data = 8'h00;
        vec_rd = 0; vec_lo = 0; dec_vld = 0; dec_illegal = 0; dec_halt = 0;
    endtask

    // drive one cycle of bus activity, then wait for the registered result
    task automatic bus(input logic v, input logic op, input logic [15:0] a,
                       input logic [7:0] d, input logic vr, input logic vl);
        idle_in();
        bus_vld = v; bus_is_op = op; bus_addr = a; bus_data = d;
        vec_rd = vr; vec_lo = vl;
        @(negedge clk);
    endtask

    task automatic dec(input logic v, input logic ill, input logic h);
        idle_in();
        dec_vld = v; dec_illegal = ill; dec_halt = h;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [2:0] ec, input logic ef);
        checks++;
        if (rst_cause !== ec || rst_req !== (ec != 3'b000) || force_mon !== ef) begin
            fails++;
            $display("FAIL %s: cause=%b req=%b force=%b expected cause=%b req=%b force=%b",
                     req, rst_cause, rst_req, force_mon, ec, (ec != 3'b000), ef);
        end
    endtask

    initial begin
        idle_in();
        rst = 1; por_rst = 1;
        repeat (3) @(negedge clk);
        chk("R10 reset state", 3'b000, 1'b0);
        rst = 0; por_rst = 0;
        @(negedge clk);

        cur_req = "R1";
        bus(1, 1, 16'h4000, 8'h00, 0, 0); chk("R1 unmapped mid", 3'b010, 0);
        bus(1, 1, 16'hBFFF, 8'h00, 0, 0); chk("R1 below flash", 3'b010, 0);
        bus(1, 1, 16'h0360, 8'h00, 0, 0); chk("R1 above ram", 3'b010, 0);
        bus(1, 1, 16'h005F, 8'h00, 0, 0); chk("R1 below ram", 3'b010, 0);
        bus(0, 0, 16'h0000, 8'h00, 0, 0); chk("R10 request falls", 3'b000, 0);

        cur_req = "R3";
        bus(1, 1, F_LO, 8'h00, 0, 0); chk("R3 flash start", 3'b000, 0);
        bus(1, 1, F_HI, 8'h00, 0, 0); chk("R3 flash end", 3'b000, 0);
        bus(1, 1, R_LO, 8'h00, 0, 0); chk("R3 ram start", 3'b000, 0);
        bus(1, 1, R_HI, 8'h00, 0, 0); chk("R3 ram end", 3'b000, 0);

        cur_req = "R2";
        bus(1, 0, 16'h4000, 8'h00, 0, 0); chk("R2 data read unmapped", 3'b000, 0);
        bus(1, 0, 16'hBFFF, 8'hFF, 0, 0); chk("R2 data read gap", 3'b000, 0);

        cur_req = "R11";
        bus(0, 1, 16'h4000, 8'hFF, 0, 0); chk("R11 no strobe", 3'b000, 0);

        cur_req = "R4";
        dec(1, 1, 0); chk("R4 illegal opcode", 3'b001, 0);
        cur_req = "R5";
        dec(1, 0, 1); chk("R5 halt opcode", 3'b001, 0);
        cur_req = "R6";
        dec(0, 1, 1); chk("R6 decode not valid", 3'b000, 0);

        cur_req = "R7";
        bus(1, 0, 16'hFFFE, 8'hFF, 1, 0); chk("R7 high byte alone", 3'b000, 0);
        bus(1, 0, 16'hFFFF, 8'h12, 1, 1); chk("R7 low programmed", 3'b000, 0);
        bus(1, 0, 16'hFFFE, 8'h34, 1, 0); chk("R7 high programmed", 3'b000, 0);
        bus(1, 0, 16'hFFFF, 8'hFF, 1, 1); chk("R7 low erased only", 3'b000, 0);
        bus(0, 0, 16'hFFFE, 8'hFF, 1, 0); chk("R11 vector without strobe", 3'b000, 0);
        bus(1, 0, 16'hFFFF, 8'hFF, 1, 1); chk("R11 stale high ignored", 3'b000, 0);
        bus(1, 0, 16'hFFFE, 8'hFF, 1, 0);
        bus(1, 0, 16'hFFFF, 8'hFF, 1, 1); chk("R7 both erased", 3'b100, 1);

        cur_req = "R8";
        bus(0, 0, 16'h0000, 8'h00, 0, 0); chk("R8 flag held", 3'b000, 1);
        rst = 1; @(negedge clk); rst = 0;
        chk("R8 flag survives rst", 3'b000, 1);
        dec(1, 1, 0); chk("R8 flag with later fault", 3'b001, 1);
        por_rst = 1; @(negedge clk); por_rst = 0;
        chk("R8 por clears flag", 3'b000, 0);

        cur_req = "R9";
        bus(1, 0, 16'hFFFE, 8'hFF, 1, 0);
        idle_in();
        bus_vld = 1; bus_is_op = 1; bus_addr = 16'h4000; bus_data = 8'hFF;
        vec_rd = 1; vec_lo = 1; dec_vld = 1; dec_illegal = 1;
        @(negedge clk);
        chk("R9 all three causes", 3'b111, 1);
        idle_in();
        dec_vld = 1; dec_halt = 1; bus_vld = 1; bus_is_op = 1; bus_addr = 16'h0400;
        @(negedge clk);
        chk("R9 op and addr", 3'b011, 1);

        cur_req = "R10";
        idle_in(); dec_vld = 1; dec_illegal = 1; rst = 1;
        @(negedge clk); rst = 0;
        chk("R10 rst drops request", 3'b000, 1);

        // random stream against the model
        cur_req = "R9";
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            case ($urandom_range(0, 5))
                0: a = F_LO - 16'd1 + 16'($urandom_range(0, 2));
                1: a = R_LO - 16'd1 + 16'($urandom_range(0, 2));
                2: a = R_HI - 16'd1 + 16'($urandom_range(0, 2));
                3: a = F_HI - 16'($urandom_range(0, 1));
                default: a = 16'($urandom);
            endcase
            bus_vld = 1'($urandom); bus_is_op = 1'($urandom); bus_addr = a;
            bus_data = ($urandom_range(0, 1) != 0) ? 8'hFF : 8'($urandom);
            vec_rd = 1'($urandom); vec_lo = 1'($urandom);
            dec_vld = 1'($urandom); dec_illegal = ($urandom_range(0, 3) == 0);
            dec_halt = ($urandom_range(0, 3) == 0);
            rst = ($urandom_range(0, 40) == 0);
            por_rst = ($urandom_range(0, 150) == 0);
            @(negedge clk);
        end
        rst = 0; por_rst = 0; idle_in();
        @(negedge clk);
        finish_run();
    end

endmodule